// File: doc/BRIEF.md
# EEPROM Word Reprogramming Sequencer

This block carries out the self-timed reprogramming of a single word in a 512 x 8 nonvolatile array once the serial bus front end has received a complete program transaction. The front end hands over a 9-bit word address and a data byte as a one-cycle request. The sequencer then runs two phases, each timed by a cycle counter. The erase phase drives every bit of the word to one. The write phase clears the bits whose data bits are zero. Either phase is left out when it would change nothing, which shortens the busy time.

While the sequencer is busy, the front end uses the busy output to refuse read-select words. A write-select word seen during that time is passed in as an abort, which ends the cycle on the next clock. Requests are dropped in three cases: when the write-protect input holds, while the power-on hold period is still running, and while a cycle is already in progress. A request for address 0 with data FF hex, made while the total-erase strap is active, erases the whole array instead. The array is modelled as a register file, and a read port lets the front end fetch words.

Top module: `eep_prog_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `busy` is low.
- R2: Requests are ignored during the first POR_CYC clock cycles after reset release. `busy` stays low and the array is unchanged.
- R3: A request made while `wp_float` is high is ignored. `busy` stays low and the addressed word keeps its value.
- R4: When the stored word is not FF and the data byte is not FF, `busy` is high for ERASE_CYC + WRITE_CYC cycles. Afterwards the word reads back as the data byte.
- R5: When the data byte is FF and the word is not FF, only the erase phase runs. `busy` lasts ERASE_CYC cycles and the word reads FF.
- R6: When the stored word is already FF, the erase phase is skipped. `busy` lasts WRITE_CYC cycles and the word reads back as the data byte.
- R7: When both the word and the data byte are FF, `busy` is high for exactly one cycle and the word stays FF.
- R8: A one-cycle `wsel_abort` pulse while busy makes `busy` low on the next clock. An abort during the erase phase leaves the word unchanged. An abort during the write phase leaves the word at FF.
- R9: A request that arrives while `busy` is high is ignored.
- R10: A request with address 0, data FF and `erase_all_strap` high sets every word to FF, with `busy` high for FULL_CYC cycles.
- R11: With `erase_all_strap` high, a request with any other address or data is handled as an ordinary single-word program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| req_valid | input | 1 | One-cycle program request |
| req_addr | input | 9 | Word address of the request |
| req_data | input | 8 | Data byte of the request |
| wsel_abort | input | 1 | Write-select seen while busy; terminates the cycle |
| wp_float | input | 1 | Write-protect condition; requests are ignored when high |
| erase_all_strap | input | 1 | Total-erase strap, sampled with the request |
| busy | output | 1 | High while a programming cycle runs |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
A wrong phase decision shows up at the ports in two ways. The `busy` pulse has the wrong length, and the bench measures that length exactly for all four skip combinations. The word read back once `busy` falls is also wrong. A wrong timer load or a missed phase end changes the `busy` length by at least one cycle within a single request. A wrongly handled abort shows at the very next clock: either `busy` is still high, or the word holds a value from a later phase. The power-on hold and the write-protect gating show within one cycle of the request, because `busy` rises.

// File: rtl/eep_seq_pkg.sv
package eep_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ERASE  = 3'd1,
    ST_WRITE  = 3'd2,
    ST_SETTLE = 3'd3,
    ST_FULL   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/eep_por_gate.sv
module eep_por_gate #(
  parameter int POR_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic por_ok
);
  localparam int PW = $clog2(POR_CYC + 1) + 1;

  logic [PW-1:0] cnt_q;

  assign por_ok = (cnt_q == PW'(POR_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!por_ok) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/eep_phase_timer.sv
module eep_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (!done) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/eep_word_array.sv
module eep_word_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          clr_all,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  always_ff @(posedge clk) begin
    if (clr_all) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '1;
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
  import eep_seq_pkg::*;
#(
  parameter int AW        = 9,
  parameter int DW        = 8,
  parameter int ERASE_CYC = 250000,
  parameter int WRITE_CYC = 250000,
  parameter int FULL_CYC  = 1000000,
  parameter int POR_CYC   = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          wsel_abort,
  input  logic          wp_float,
  input  logic          erase_all_strap,
  output logic          busy,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int MAXC = (FULL_CYC > ERASE_CYC) ?
                        ((FULL_CYC > WRITE_CYC) ? FULL_CYC : WRITE_CYC) :
                        ((ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_ERASE = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] LD_WRITE = CW'(WRITE_CYC - 1);
  localparam logic [CW-1:0] LD_FULL  = CW'(FULL_CYC - 1);
  localparam logic [DW-1:0] ONES     = '1;

  seq_state_e    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          por_ok;
  logic          tdone;
  logic          accept;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          arr_we;
  logic [DW-1:0] arr_wdata;
  logic          arr_clr;
  logic [AW-1:0] int_addr;
  logic [DW-1:0] int_rdata;
  logic          need_erase;
  logic          need_write;
  logic          full_req;

  eep_por_gate #(.POR_CYC(POR_CYC)) u_por (
    .clk    (clk),
    .rst_n  (rst_n),
    .por_ok (por_ok)
  );

  eep_phase_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .done     (tdone)
  );

  eep_word_array #(.AW(AW), .DW(DW)) u_arr (
    .clk     (clk),
    .we      (arr_we),
    .waddr   (addr_q),
    .wdata   (arr_wdata),
    .clr_all (arr_clr),
    .raddr_a (int_addr),
    .rdata_a (int_rdata),
    .raddr_b (rd_addr),
    .rdata_b (rd_data)
  );

  assign busy       = (st_q != ST_IDLE);
  assign accept     = req_valid && !busy && por_ok && !wp_float;
  assign int_addr   = busy ? addr_q : req_addr;
  assign need_erase = (int_rdata != ONES);
  assign need_write = busy ? (data_q != ONES) : (req_data != ONES);
  assign full_req   = erase_all_strap && (req_addr == '0) && (req_data == ONES);

  always_comb begin
    st_d      = st_q;
    ld        = 1'b0;
    ld_val    = '0;
    arr_we    = 1'b0;
    arr_wdata = ONES;
    arr_clr   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          ld = 1'b1;
          if (full_req) begin
            st_d   = ST_FULL;
            ld_val = LD_FULL;
          end else if (need_erase) begin
            st_d   = ST_ERASE;
            ld_val = LD_ERASE;
          end else if (need_write) begin
            st_d   = ST_WRITE;
            ld_val = LD_WRITE;
          end else begin
            st_d   = ST_SETTLE;
          end
        end
      end
      ST_ERASE: begin
        if (wsel_abort) begin
          st_d = ST_IDLE;
        end else if (tdone) begin
          arr_we    = 1'b1;
          arr_wdata = ONES;
          if (need_write) begin
            st_d   = ST_WRITE;
            ld     = 1'b1;
            ld_val = LD_WRITE;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (wsel_abort) begin
          st_d = ST_IDLE;
        end else if (tdone) begin
          arr_we    = 1'b1;
          arr_wdata = int_rdata & data_q;
          st_d      = ST_IDLE;
        end
      end
      ST_FULL: begin
        if (wsel_abort) begin
          st_d = ST_IDLE;
        end else if (tdone) begin
          arr_clr = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '1;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end
endmodule

// File: rtl/eep_prog_seq_chk.sv
module eep_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic wp_float,
  input logic wsel_abort,
  input logic busy,
  input logic por_ok,
  input logic tdone
);
  a_r8_abort_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wsel_abort) |=> !busy);

  a_r3_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && wp_float) |=> !busy);

  a_r2_por_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !por_ok) |=> !busy);

  a_r4_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !wp_float && por_ok) |=> busy);

  a_r4_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wsel_abort && !tdone) |=> busy);

  a_r1_reset_idle: assert property (@(posedge clk)
    (!rst_n) |-> !busy);
endmodule

bind eep_prog_seq eep_prog_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .wp_float   (wp_float),
  .wsel_abort (wsel_abort),
  .busy       (busy),
  .por_ok     (por_ok),
  .tdone      (tdone)
);

// File: tb/eep_prog_seq_tb.sv
module eep_prog_seq_tb;
  localparam int EC = 20;
  localparam int WC = 30;
  localparam int FC = 50;
  localparam int PC = 16;

  typedef struct packed {
    logic [8:0] addr;
    logic [7:0] data;
    int         cyc;
    logic [7:0] expw;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{9'h005, 8'hA5, WC,      8'hA5},  // R6 erase skipped
    '{9'h005, 8'h3C, EC + WC, 8'h3C},  // R4 erase + write
    '{9'h005, 8'hFF, EC,      8'hFF},  // R5 write skipped
    '{9'h005, 8'hFF, 1,       8'hFF},  // R7 both skipped
    '{9'h1FF, 8'h00, WC,      8'h00},  // R6 top address
    '{9'h000, 8'hFF, 1,       8'hFF}   // R7 address 0 without strap
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, wsel_abort, wp_float, erase_all_strap;
  logic [8:0] req_addr, rd_addr;
  logic [7:0] req_data, rd_data;
  logic       busy;
  int         checks = 0;
  int         errors = 0;
  int         cyc_cnt = 0;

  always #5 clk = ~clk;

  eep_prog_seq #(
    .ERASE_CYC (EC),
    .WRITE_CYC (WC),
    .FULL_CYC  (FC),
    .POR_CYC   (PC)
  ) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_data        (req_data),
    .wsel_abort      (wsel_abort),
    .wp_float        (wp_float),
    .erase_all_strap (erase_all_strap),
    .busy            (busy),
    .rd_addr         (rd_addr),
    .rd_data         (rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [8:0] a, input logic [7:0] d, input logic strap);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; erase_all_strap = strap;
    @(negedge clk);
    req_valid = 1'b0; erase_all_strap = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_word(input logic [8:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_cnt);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] w;
    rst_n = 1'b0; req_valid = 1'b0; wsel_abort = 1'b0; wp_float = 1'b0;
    erase_all_strap = 1'b0; req_addr = '0; req_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    check("R1 busy after release", int'(busy), 0);

    // R2: request inside power-on hold is dropped
    issue(9'h000, 8'hFF, 1'b1);
    check("R2 request during hold", int'(busy), 0);
    repeat (PC + 4) @(negedge clk);

    // R3: write protect
    wp_float = 1'b1;
    issue(9'h000, 8'hFF, 1'b1);
    check("R3 protected request", int'(busy), 0);
    wp_float = 1'b0;

    // R10: total erase
    issue(9'h000, 8'hFF, 1'b1);
    busy_len(n);
    check("R10 total erase length", n, FC);
    read_word(9'h000, w); check("R10 word 0", int'(w), 8'hFF);
    read_word(9'h0AB, w); check("R10 word AB", int'(w), 8'hFF);
    read_word(9'h1FF, w); check("R10 word 1FF", int'(w), 8'hFF);

    // R4..R7 vector table
    for (int i = 0; i < 6; i++) begin
      issue(VEC[i].addr, VEC[i].data, 1'b0);
      busy_len(n);
      check("R4-R7 table busy length", n, VEC[i].cyc);
      read_word(VEC[i].addr, w);
      check("R4-R7 table word", int'(w), int'(VEC[i].expw));
    end

    // R11: strap with other address is single-word
    issue(9'h003, 8'h12, 1'b1);
    busy_len(n);
    check("R11 strap other address length", n, WC);
    read_word(9'h003, w); check("R11 word 3", int'(w), 8'h12);
    read_word(9'h1FF, w); check("R11 word 1FF kept", int'(w), 8'h00);

    // R9: request while busy ignored
    issue(9'h00A, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    issue(9'h00B, 8'h00, 1'b0);
    busy_len(n);
    check("R9 first request length", n + 5, WC);
    read_word(9'h00B, w); check("R9 word B untouched", int'(w), 8'hFF);
    read_word(9'h00A, w); check("R9 word A written", int'(w), 8'h00);

    // R8: abort in erase phase
    issue(9'h00A, 8'h55, 1'b0);
    repeat (4) @(negedge clk);
    wsel_abort = 1'b1;
    @(negedge clk);
    wsel_abort = 1'b0;
    check("R8 busy after abort", int'(busy), 0);
    read_word(9'h00A, w); check("R8 erase abort word", int'(w), 8'h00);

    // R8: abort in write phase
    issue(9'h00A, 8'h55, 1'b0);
    repeat (EC + 4) @(negedge clk);
    check("R8 still busy before abort", int'(busy), 1);
    wsel_abort = 1'b1;
    @(negedge clk);
    wsel_abort = 1'b0;
    check("R8 busy after write abort", int'(busy), 0);
    read_word(9'h00A, w); check("R8 write abort word", int'(w), 8'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule